// File: doc/BRIEF.md
# Handshaked Buffered Parallel Port

This block is one byte-wide parallel port. A CPU reaches it through four registers, and a peripheral reaches it through a data bus with a per-bit direction and two handshake lines. The strobe line is always an input from the peripheral. The auxiliary line can be an edge-sensitive input, a static output level, or the port's ready signal in an interlocked or pulsed handshake.

A two-bit buffering field in the control register sets both the data flow and the direction that the handshake serves:
- In the latched-input setting, a strobe edge captures the pins into a two-entry queue.
- In the double-buffered output setting, the CPU can stage two bytes, and each strobe edge acknowledges one of them.
- In the plain setting, input reads see the live pins and output is single-buffered.

A maskable interrupt request combines the two event flags.

Top module: `hs_par_port`

## Requirements
- R1: After reset, the direction, control and status event bits read 0. `pin_oe_o`, `aux_oe_o` and `irq_o` are low.
- R2: Register map: address 0 is data, 1 is direction, 2 is control, 3 is status. A write to address 1 sets `pin_oe_o` (1 = drive) and reads back unchanged.
- R3: Control bits [1:0] = 00 select latched input. Each rising edge of `strb_i` captures `pin_i`. Data reads return the captured bytes oldest first and remove each one as it is read.
- R4: The latched-input queue holds two bytes. A strobe edge while it is full is dropped. With auxiliary mode 110, `aux_o` is high exactly while the queue has room.
- R5: With buffering 01 or 1x, a data read returns `pin_i` on input bits and the output register on output bits. Strobe edges capture nothing.
- R6: With buffering 1x and auxiliary mode 110, a data write loads `pin_o` and raises `aux_o`. A further write is dropped while `aux_o` is high. The next `strb_i` rising edge lowers `aux_o`.
- R7: With buffering 01 and auxiliary mode 110, two writes are accepted and a third is dropped. On the first acknowledge edge, `pin_o` advances to the second byte and `aux_o` stays high. On the second acknowledge edge, `aux_o` falls.
- R8: Auxiliary mode 111 raises `aux_o` for exactly PULSE_CYC (4) cycles each time an output byte is accepted.
- R9: Auxiliary control bits [4:2] select the line's behaviour:
  - 100 drives `aux_o` low and 101 drives it high; both set `aux_oe_o`.
  - 0xx releases the line (`aux_oe_o` low).
- R10: Status bit 0:
  - With buffering 00 it is 1 while the queue is non-empty.
  - Otherwise it is a sticky strobe-edge flag, cleared by writing 1 to bit 0.
- R11: Status bit 1:
  - In auxiliary modes 0xx it is a sticky rising-edge flag of `aux_i`, cleared by writing 1 to bit 1.
  - Otherwise it is 1 when a data write would be accepted.
- R12: `irq_o` = (status bit 0 AND control bit 5) OR (status bit 1 AND control bit 6).
- R13: Status bits 2 and 3 show the live levels of `strb_i` and `aux_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops queue on data reads) |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | W | Write data |
| reg_rdata_o | output | W | Read data |
| pin_i | input | W | Port pin levels |
| pin_o | output | W | Port output value |
| pin_oe_o | output | W | Per-bit output enable |
| strb_i | input | 1 | Strobe / acknowledge from peripheral |
| aux_i | input | 1 | Auxiliary handshake input |
| aux_o | output | 1 | Auxiliary handshake output |
| aux_oe_o | output | 1 | Auxiliary output enable |
| irq_o | output | 1 | Interrupt request |

## Verification
The latched-input queue is driven by a seeded random mix of strobe edges and data reads. This stresses fill, drain and drop-on-full against a two-entry model, and the ready level is checked after every step.

Directed sequences cover the other behaviours:
- Two writes then two acknowledges separate single from double output buffering.
- Counting the high cycles of the ready line separates pulsed from interlocked handshakes.
- A mixed direction mask with differing pin and register values shows that each read bit comes from the right source.

// File: rtl/hpp_pkg.sv
`timescale 1ns/1ps
package hpp_pkg;
  typedef enum logic [1:0] {
    SUB_IN_DB  = 2'b00,
    SUB_OUT_DB = 2'b01,
    SUB_NL_0   = 2'b10,
    SUB_NL_1   = 2'b11
  } sub_e;

  localparam logic [2:0] AUX_LOW   = 3'b100;
  localparam logic [2:0] AUX_HIGH  = 3'b101;
  localparam logic [2:0] AUX_ILK   = 3'b110;
  localparam logic [2:0] AUX_PULSE = 3'b111;

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_DIR  = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  typedef struct packed {
    logic       spare;
    logic       ie_aux;
    logic       ie_strb;
    logic [2:0] aux_mode;
    sub_e       sub;
  } ctrl_t;
endpackage

// File: rtl/hpp_in_fifo.sv
`timescale 1ns/1ps
module hpp_in_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/hpp_out_buf.sv
`timescale 1ns/1ps
module hpp_out_buf #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         hs_en_i,
  input  logic         dbl_i,
  input  logic         ack_i,
  output logic [W-1:0] data_o,
  output logic         pend_o,
  output logic         space_o,
  output logic         load_o
);
  logic [W-1:0] out_q, hold_q, out_d, hold_d;
  logic         pend_q, hv_q, pend_d, hv_d;

  always_comb begin
    out_d  = out_q;
    hold_d = hold_q;
    pend_d = pend_q;
    hv_d   = hv_q;
    load_o = 1'b0;
    if (hs_en_i) begin
      if (ack_i && pend_q) begin
        if (hv_q) begin
          out_d  = hold_q;
          hv_d   = 1'b0;
          load_o = 1'b1;
        end else begin
          pend_d = 1'b0;
        end
      end
      if (wr_i) begin
        if (!pend_d) begin
          out_d  = wdata_i;
          pend_d = 1'b1;
          load_o = 1'b1;
        end else if (dbl_i && !hv_d) begin
          hold_d = wdata_i;
          hv_d   = 1'b1;
        end
      end
    end else begin
      pend_d = 1'b0;
      hv_d   = 1'b0;
      if (wr_i) out_d = wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      hold_q <= '0;
      pend_q <= 1'b0;
      hv_q   <= 1'b0;
    end else begin
      out_q  <= out_d;
      hold_q <= hold_d;
      pend_q <= pend_d;
      hv_q   <= hv_d;
    end
  end

  assign data_o  = out_q;
  assign pend_o  = pend_q;
  assign space_o = !hs_en_i || !pend_q || (dbl_i && !hv_q);
endmodule

// File: rtl/hpp_hs_ctrl.sv
`timescale 1ns/1ps
module hpp_hs_ctrl
  import hpp_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       strb_i,
  input  logic       aux_i,
  input  logic [2:0] mode_i,
  input  logic       in_mode_i,
  input  logic       in_full_i,
  input  logic       pend_i,
  input  logic       trig_i,
  output logic       strb_edge_o,
  output logic       aux_edge_o,
  output logic       aux_o,
  output logic       aux_oe_o
);
  localparam int unsigned CW = $clog2(PULSE_CYC + 1);

  logic          strb_q, aux_q;
  logic [CW-1:0] pcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strb_q <= 1'b0;
      aux_q  <= 1'b0;
      pcnt_q <= '0;
    end else begin
      strb_q <= strb_i;
      aux_q  <= aux_i;
      if (mode_i == AUX_PULSE && trig_i) pcnt_q <= CW'(PULSE_CYC);
      else if (pcnt_q != '0)             pcnt_q <= pcnt_q - 1'b1;
    end
  end

  assign strb_edge_o = strb_i && !strb_q;
  assign aux_edge_o  = aux_i && !aux_q;
  assign aux_oe_o    = mode_i[2];

  always_comb begin
    unique case (mode_i)
      AUX_LOW:   aux_o = 1'b0;
      AUX_HIGH:  aux_o = 1'b1;
      // ready: room to accept on input, data available on output
      AUX_ILK:   aux_o = in_mode_i ? !in_full_i : pend_i;
      AUX_PULSE: aux_o = (pcnt_q != '0);
      default:   aux_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/hs_par_port.sv
`timescale 1ns/1ps
module hs_par_port
  import hpp_pkg::*;
#(
  parameter int unsigned W         = 8,
  parameter int unsigned IN_DEPTH  = 2,
  parameter int unsigned PULSE_CYC = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         reg_we_i,
  input  logic         reg_re_i,
  input  logic [1:0]   reg_addr_i,
  input  logic [W-1:0] reg_wdata_i,
  output logic [W-1:0] reg_rdata_o,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_o,
  output logic [W-1:0] pin_oe_o,
  input  logic         strb_i,
  input  logic         aux_i,
  output logic         aux_o,
  output logic         aux_oe_o,
  output logic         irq_o
);
  logic [W-1:0] dir_q;
  ctrl_t        ctrl_q;
  logic         flag_s_q, flag_a_q;
  logic         in_mode, strb_edge, aux_edge;
  logic         push, pop, acc, trig;
  logic [W-1:0] fifo_head, out_data, in_src;
  logic         fifo_empty, fifo_full;
  logic         out_pend, out_space, out_load, out_hs_en, out_dbl;
  logic         st_s, st_a;
  logic [7:0]   stat;
  logic         wr_data, wr_stat;

  assign in_mode   = (ctrl_q.sub == SUB_IN_DB);
  assign out_dbl   = (ctrl_q.sub == SUB_OUT_DB);
  assign out_hs_en = !in_mode && (ctrl_q.aux_mode[2:1] == 2'b11);
  assign wr_data   = reg_we_i && (reg_addr_i == A_DATA);
  assign wr_stat   = reg_we_i && (reg_addr_i == A_STAT);
  assign push      = in_mode && strb_edge;
  assign acc       = push && !fifo_full;
  assign pop       = in_mode && reg_re_i && (reg_addr_i == A_DATA);
  assign trig      = in_mode ? acc : out_load;

  hpp_in_fifo #(.W(W), .DEPTH(IN_DEPTH)) u_in_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .data_i  (pin_i),
    .pop_i   (pop),
    .head_o  (fifo_head),
    .empty_o (fifo_empty),
    .full_o  (fifo_full)
  );

  hpp_out_buf #(.W(W)) u_out_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_data),
    .wdata_i (reg_wdata_i),
    .hs_en_i (out_hs_en),
    .dbl_i   (out_dbl),
    .ack_i   (strb_edge),
    .data_o  (out_data),
    .pend_o  (out_pend),
    .space_o (out_space),
    .load_o  (out_load)
  );

  hpp_hs_ctrl #(.PULSE_CYC(PULSE_CYC)) u_hs_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .strb_i      (strb_i),
    .aux_i       (aux_i),
    .mode_i      (ctrl_q.aux_mode),
    .in_mode_i   (in_mode),
    .in_full_i   (fifo_full),
    .pend_i      (out_pend),
    .trig_i      (trig),
    .strb_edge_o (strb_edge),
    .aux_edge_o  (aux_edge),
    .aux_o       (aux_o),
    .aux_oe_o    (aux_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q    <= '0;
      ctrl_q   <= '0;
      flag_s_q <= 1'b0;
      flag_a_q <= 1'b0;
    end else begin
      if (reg_we_i && reg_addr_i == A_DIR)  dir_q  <= reg_wdata_i;
      if (reg_we_i && reg_addr_i == A_CTRL) ctrl_q <= ctrl_t'(reg_wdata_i[7:0]);
      // set wins over write-one-to-clear
      if (!in_mode && strb_edge)                   flag_s_q <= 1'b1;
      else if (wr_stat && reg_wdata_i[0])          flag_s_q <= 1'b0;
      if (!ctrl_q.aux_mode[2] && aux_edge)         flag_a_q <= 1'b1;
      else if (wr_stat && reg_wdata_i[1])          flag_a_q <= 1'b0;
    end
  end

  assign st_s  = in_mode ? !fifo_empty : flag_s_q;
  assign st_a  = ctrl_q.aux_mode[2] ? out_space : flag_a_q;
  assign stat  = {4'b0000, aux_i, strb_i, st_a, st_s};
  assign irq_o = (st_s && ctrl_q.ie_strb) || (st_a && ctrl_q.ie_aux);

  assign in_src = in_mode ? fifo_head : pin_i;

  always_comb begin
    unique case (reg_addr_i)
      A_DATA:  reg_rdata_o = (dir_q & out_data) | (~dir_q & in_src);
      A_DIR:   reg_rdata_o = dir_q;
      A_CTRL:  reg_rdata_o = W'(ctrl_q);
      default: reg_rdata_o = W'(stat);
    endcase
  end

  assign pin_o    = out_data;
  assign pin_oe_o = dir_q;
endmodule

// File: rtl/hs_par_port_chk.sv
`timescale 1ns/1ps
module hs_par_port_chk
  import hpp_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         reg_we_i,
  input logic [1:0]   reg_addr_i,
  input logic [W-1:0] reg_wdata_i,
  input logic [W-1:0] pin_oe_o,
  input logic         aux_o,
  input logic         aux_oe_o,
  input logic         irq_o,
  input logic [7:0]   ctrl_q,
  input logic         in_mode,
  input logic         strb_edge,
  input logic         fifo_full,
  input logic         pop
);
  // R2
  dir_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == A_DIR) |=> (pin_oe_o == $past(reg_wdata_i)));

  // R9
  aux_static_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == A_CTRL && reg_wdata_i[4:3] == 2'b10)
      |=> (aux_oe_o && aux_o == $past(reg_wdata_i[2])));

  // R12
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[6:5] == 2'b00) |-> !irq_o);

  // R4
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_mode && fifo_full && strb_edge && !pop) |=> fifo_full);

  // R6
  ilk_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(aux_o) && ctrl_q[4:2] == AUX_ILK && $past(ctrl_q[4:2]) == AUX_ILK
      && !in_mode && $past(!in_mode))
      |-> $past(reg_we_i && reg_addr_i == A_DATA));
endmodule

bind hs_par_port hs_par_port_chk #(.W(W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .pin_oe_o    (pin_oe_o),
  .aux_o       (aux_o),
  .aux_oe_o    (aux_oe_o),
  .irq_o       (irq_o),
  .ctrl_q      (ctrl_q),
  .in_mode     (in_mode),
  .strb_edge   (strb_edge),
  .fifo_full   (fifo_full),
  .pop         (pop)
);

// File: tb/tb_hs_par_port.sv
`timescale 1ns/1ps
module tb_hs_par_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 0, re = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata, pin = 0, pin_out, pin_oe;
  logic       strb = 0, aux = 0, aux_out, aux_oe, irq;
  int         checks = 0, errs = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  hs_par_port dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .pin_i(pin), .pin_o(pin_out), .pin_oe_o(pin_oe),
    .strb_i(strb), .aux_i(aux), .aux_o(aux_out), .aux_oe_o(aux_oe),
    .irq_o(irq)
  );

  function automatic logic [7:0] mix(input logic [7:0] d, input logic [7:0] o, input logic [7:0] p);
    return (d & o) | (~d & p);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); re = 1; addr = a;
    #1 d = rdata;
    @(negedge clk); re = 0;
  endtask

  task automatic strobe(input logic [7:0] p);
    @(negedge clk); pin = p; strb = 1;
    @(negedge clk); strb = 0;
  endtask

  task automatic aux_pulse();
    @(negedge clk); aux = 1;
    @(negedge clk); aux = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #500000;
    errs++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    logic [7:0] q[$];
    int n;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk(pin_oe == 0 && aux_oe == 0 && irq == 0, "R1 outputs", {pin_oe, aux_oe, irq}, 0);
    rd(2'd1, v); chk(v == 0, "R1 dir", v, 0);
    rd(2'd2, v); chk(v == 0, "R1 ctrl", v, 0);
    rd(2'd3, v); chk(v[1:0] == 0, "R1 status", v, 0);

    // R2 direction
    wr(2'd1, 8'hA5);
    chk(pin_oe == 8'hA5, "R2 oe", pin_oe, 8'hA5);
    rd(2'd1, v); chk(v == 8'hA5, "R2 readback", v, 8'hA5);

    // R5 non-latched read mix
    wr(2'd2, 8'h02); wr(2'd1, 8'hF0); wr(2'd3, 8'h03);
    wr(2'd0, 8'h3C);
    chk(pin_out == 8'h3C, "R5 pin_o", pin_out, 8'h3C);
    pin = 8'h96;
    rd(2'd0, v); chk(v == mix(8'hF0, 8'h3C, 8'h96), "R5 mix", v, mix(8'hF0, 8'h3C, 8'h96));
    strobe(8'h5A);
    rd(2'd0, v); chk(v == mix(8'hF0, 8'h3C, 8'h5A), "R5 live", v, mix(8'hF0, 8'h3C, 8'h5A));
    // R10 sticky flag and clear
    rd(2'd3, v); chk(v[0] == 1, "R10 set", v[0], 1);
    wr(2'd3, 8'h01);
    rd(2'd3, v); chk(v[0] == 0, "R10 clear", v[0], 0);

    // R6 single-buffered interlocked output
    wr(2'd1, 8'hFF); wr(2'd2, 8'h1A);
    chk(aux_out == 0, "R6 idle", aux_out, 0);
    wr(2'd0, 8'h11);
    chk(aux_out == 1 && pin_out == 8'h11, "R6 load", {aux_out, pin_out}, {1'b1, 8'h11});
    rd(2'd3, v); chk(v[1] == 0, "R11 no space", v[1], 0);
    wr(2'd0, 8'h22);
    chk(pin_out == 8'h11, "R6 drop", pin_out, 8'h11);
    strobe(8'h00);
    chk(aux_out == 0, "R6 ack", aux_out, 0);
    rd(2'd3, v); chk(v[1] == 1, "R11 space", v[1], 1);

    // R7 double-buffered output
    wr(2'd2, 8'h19);
    wr(2'd0, 8'hAA); wr(2'd0, 8'hBB);
    chk(pin_out == 8'hAA && aux_out == 1, "R7 first", {aux_out, pin_out}, {1'b1, 8'hAA});
    rd(2'd3, v); chk(v[1] == 0, "R7 full", v[1], 0);
    wr(2'd0, 8'hCC);
    strobe(8'h00);
    chk(pin_out == 8'hBB && aux_out == 1, "R7 advance", {aux_out, pin_out}, {1'b1, 8'hBB});
    strobe(8'h00);
    chk(pin_out == 8'hBB && aux_out == 0, "R7 drained", {aux_out, pin_out}, {1'b0, 8'hBB});

    // R8 pulsed output
    wr(2'd2, 8'h1E);
    wr(2'd0, 8'h44);
    n = 0;
    while (aux_out && n < 20) begin n++; @(negedge clk); end
    chk(n == 4, "R8 width", n, 4);
    strobe(8'h00);

    // R9 static levels
    wr(2'd2, 8'h10);
    chk(aux_oe == 1 && aux_out == 0, "R9 low", {aux_oe, aux_out}, 2'b10);
    wr(2'd2, 8'h14);
    chk(aux_oe == 1 && aux_out == 1, "R9 high", {aux_oe, aux_out}, 2'b11);
    wr(2'd2, 8'h00);
    chk(aux_oe == 0, "R9 input", aux_oe, 0);

    // R11 aux edge flag
    wr(2'd2, 8'h02); wr(2'd3, 8'h03);
    aux_pulse();
    rd(2'd3, v); chk(v[1] == 1, "R11 set", v[1], 1);
    wr(2'd3, 8'h02);
    rd(2'd3, v); chk(v[1] == 0, "R11 clear", v[1], 0);

    // R12 interrupt
    strobe(8'h00);
    chk(irq == 0, "R12 masked", irq, 0);
    wr(2'd3, 8'h03); wr(2'd2, 8'h22);
    strobe(8'h00);
    chk(irq == 1, "R12 strobe irq", irq, 1);
    wr(2'd3, 8'h01);
    chk(irq == 0, "R12 cleared", irq, 0);
    wr(2'd2, 8'h42);
    aux_pulse();
    chk(irq == 1, "R12 aux irq", irq, 1);
    wr(2'd3, 8'h02);
    chk(irq == 0, "R12 aux cleared", irq, 0);

    // R13 live levels
    @(negedge clk); strb = 1; aux = 1;
    rd(2'd3, v); chk(v[3:2] == 2'b11, "R13 levels", v[3:2], 2'b11);
    strb = 0; aux = 0;
    rd(2'd3, v); chk(v[3:2] == 2'b00, "R13 low", v[3:2], 0);

    // R4 directed: fill, drop third, drain
    wr(2'd2, 8'h18); wr(2'd1, 8'h00);
    chk(aux_out == 1, "R4 room", aux_out, 1);
    strobe(8'h12); strobe(8'h34);
    chk(aux_out == 0, "R4 full", aux_out, 0);
    strobe(8'h56);
    rd(2'd0, v); chk(v == 8'h12, "R3 oldest", v, 8'h12);
    chk(aux_out == 1, "R4 room again", aux_out, 1);
    rd(2'd0, v); chk(v == 8'h34, "R4 third dropped", v, 8'h34);
    rd(2'd3, v); chk(v[0] == 0, "R10 empty", v[0], 0);

    // R3/R4 random mix against a two-entry model
    for (int i = 0; i < 200; i++) begin
      if (($urandom % 3) != 0) begin
        logic [7:0] p;
        p = 8'($urandom);
        strobe(p);
        if (q.size() < 2) q.push_back(p);
      end else if (q.size() > 0) begin
        logic [7:0] e;
        e = q.pop_front();
        rd(2'd0, v); chk(v == e, "R3 random read", v, e);
      end
      rd(2'd3, v);
      chk(v[0] == (q.size() > 0), "R10 random", v[0], q.size() > 0);
      chk(aux_out == (q.size() < 2), "R4 random ready", aux_out, q.size() < 2);
    end

    finish_run();
  end
endmodule